// File: doc/BRIEF.md
# Flash Bulk-Erase Sequencer

This block is a host-side controller that carries a byte-wide parallel flash device through a complete bulk erase. The flash is driven through its command register with active-low chip-enable, output-enable and write-enable strobes and a bidirectional data bus. A single start pulse begins the run. The run has two phases. First the controller programs every byte to 00h, in ascending address order, and confirms each byte with a program-verify readback. It then issues the two-write erase command and lets the erase run for a timed pulse. A verify-setup write to address zero ends the pulse. The controller then walks the array, pairing one verify-setup write with one verify read for every byte.

If a byte fails to read back as FFh, the controller applies another erase pulse. Verification then resumes at that same byte, because every byte below it has already passed. The run ends with a held done flag and exactly one of pass or fail. Fail is reported when one byte needs more program attempts than allowed, or when the erase retries exceed their limit. All timing is counted in clock cycles:
- write-enable pulse width;
- erase and program pulse lengths;
- gap from a write-enable rising edge to the following output-enable falling edge;
- delay from output-enable falling to data valid.

Top module: `flash_erase_ctrl`

## Requirements
- R1: While reset is asserted and after it is released with no start, fl_ce_n, fl_we_n and fl_oe_n are 1, fl_dq_oe is 0, and busy, done, pass and fail are 0.
- R2: A start pulse while idle makes busy 1 on the next cycle. A start pulse while busy is ignored: the bus sequence continues unchanged and done stays 0.
- R3: Preprogramming visits addresses 0 to 2^ADDR_W-1 in ascending order. At each address it writes 40h, then 00h, waits PROG_CYC cycles, writes C0h, and then performs one read of the same address. A read value of 00h moves on to the next address.
- R4: A program-verify read other than 00h repeats the 40h/00h/C0h/read group at the same address. When the read fails on the PROG_TRIES-th attempt for one byte, the run ends with done=1, fail=1 and no erase command.
- R5: The erase command is two consecutive writes of 20h. The rising write-enable edge of the following A0h write comes at least ERASE_CYC cycles after the rising edge of the second 20h write.
- R6: Erase verification writes A0h with the byte's address and then reads that address. A value of FFh advances to the next address. A pass at the last address ends the run with done=1 and pass=1.
- R7: A verify read other than FFh is followed by two 20h writes, a timed erase pulse, and an A0h write to the same address. Verification does not restart from address 0.
- R8: At most MAX_RETRY extra erase pulses are issued. A failed verify when MAX_RETRY extra pulses have already been used ends the run with done=1 and fail=1. A run that needs exactly MAX_RETRY extra pulses passes.
- R9: Output-enable falls no earlier than GAP cycles after the most recent write-enable rising edge. The controller does not drive the data bus while output-enable is low. Read data is sampled OE_DLY cycles after output-enable falls.
- R10: Write-enable and output-enable are never low together. Either strobe being low implies chip-enable is low. Write-enable low implies the controller drives the data bus.
- R11: done, pass and fail hold their values until the next accepted start. pass and fail are never 1 together, and neither is 1 without done.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Pulse that begins a run when idle |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run finished; held until the next start |
| pass | output | 1 | Finished with every byte erased |
| fail | output | 1 | Finished on a program or erase retry limit |
| fl_addr | output | ADDR_W | Flash byte address |
| fl_dq_out | output | 8 | Data driven toward the flash |
| fl_dq_oe | output | 1 | Enable for the data bus driver |
| fl_dq_in | input | 8 | Data returned by the flash |
| fl_ce_n | output | 1 | Chip enable, active low |
| fl_oe_n | output | 1 | Output enable, active low |
| fl_we_n | output | 1 | Write enable, active low |

## Verification
The assertions assume the start input is a clean pulse and that fl_dq_in can take any value; no property depends on what the flash returns. They also assume the internal reset has been released before any start, because a start during the two-cycle reset release is not accepted. The stimulus pulses start only at least four cycles after reset is released.

The bench's flash model returns the real byte only after output-enable has been low for OE_DLY cycles, and returns a non-matching value before then. This keeps the model inside the timing the controller is meant to honour, while an early sample reads the wrong byte.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

  typedef enum logic {
    OP_WRITE = 1'b0,
    OP_READ  = 1'b1
  } bus_op_e;

  typedef enum logic [2:0] {
    B_IDLE,
    B_WSET,
    B_WLOW,
    B_WREC,
    B_RGAP,
    B_ROE,
    B_REND
  } bus_st_e;

  typedef enum logic [3:0] {
    S_IDLE,
    S_PP_SET,
    S_PP_DAT,
    S_PP_WAIT,
    S_PP_VSET,
    S_PP_VRD,
    S_ER_SET1,
    S_ER_SET2,
    S_ER_WAIT,
    S_EV_SET,
    S_EV_RD
  } seq_st_e;

  localparam logic [7:0] CMD_PROG_SETUP   = 8'h40;
  localparam logic [7:0] CMD_PROG_VERIFY  = 8'hC0;
  localparam logic [7:0] CMD_ERASE        = 8'h20;
  localparam logic [7:0] CMD_ERASE_VERIFY = 8'hA0;
  localparam logic [7:0] BYTE_ZERO        = 8'h00;
  localparam logic [7:0] BYTE_ERASED      = 8'hFF;

endpackage

// File: rtl/flash_wait_timer.sv
module flash_wait_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] value,
  output logic         zero
);

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load) begin
      cnt_d = value;
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign zero = (cnt_q == '0);

endmodule

// File: rtl/flash_bus_engine.sv
module flash_bus_engine
  import flash_seq_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int WE_PW  = 8,
  parameter int GAP    = 750,
  parameter int OE_DLY = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  bus_op_e           op,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic [7:0]        data_in,
  output logic              done,
  output logic [7:0]        rd_data,
  output logic [ADDR_W-1:0] fl_addr,
  output logic [7:0]        fl_dq_out,
  output logic              fl_dq_oe,
  input  logic [7:0]        fl_dq_in,
  output logic              fl_ce_n,
  output logic              fl_oe_n,
  output logic              fl_we_n
);

  localparam int TMAX = (GAP > WE_PW) ? ((GAP > OE_DLY) ? GAP : OE_DLY)
                                      : ((WE_PW > OE_DLY) ? WE_PW : OE_DLY);
  localparam int TW   = $clog2(TMAX + 1);

  bus_st_e           st_q, st_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [7:0]        data_q, data_d;
  logic [7:0]        rd_q, rd_d;
  logic              tld;
  logic [TW-1:0]     tval;
  logic              tzero;

  flash_wait_timer #(.W(TW)) u_tmr (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (tld),
    .value (tval),
    .zero  (tzero)
  );

  always_comb begin
    st_d   = st_q;
    addr_d = addr_q;
    data_d = data_q;
    rd_d   = rd_q;
    tld    = 1'b0;
    tval   = '0;
    unique case (st_q)
      B_IDLE: begin
        if (req) begin
          addr_d = addr_in;
          data_d = data_in;
          if (op == OP_WRITE) begin
            st_d = B_WSET;
          end else begin
            st_d = B_RGAP;
            tld  = 1'b1;
            tval = TW'(GAP - 1);
          end
        end
      end
      B_WSET: begin
        st_d = B_WLOW;
        tld  = 1'b1;
        tval = TW'(WE_PW - 1);
      end
      B_WLOW: if (tzero) st_d = B_WREC;
      B_WREC: st_d = B_IDLE;
      B_RGAP: begin
        if (tzero) begin
          st_d = B_ROE;
          tld  = 1'b1;
          tval = TW'(OE_DLY - 1);
        end
      end
      B_ROE: begin
        if (tzero) begin
          rd_d = fl_dq_in;
          st_d = B_REND;
        end
      end
      B_REND: st_d = B_IDLE;
      default: st_d = B_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= B_IDLE;
      addr_q <= '0;
      data_q <= '0;
      rd_q   <= '0;
    end else begin
      st_q   <= st_d;
      addr_q <= addr_d;
      data_q <= data_d;
      rd_q   <= rd_d;
    end
  end

  // Strobes are decoded from the registered state only (R9, R10)
  assign fl_addr   = addr_q;
  assign fl_dq_out = data_q;
  assign fl_dq_oe  = (st_q == B_WSET) || (st_q == B_WLOW) || (st_q == B_WREC);
  assign fl_ce_n   = (st_q == B_IDLE);
  assign fl_we_n   = (st_q != B_WLOW);
  assign fl_oe_n   = (st_q != B_ROE);
  assign done      = (st_q == B_WREC) || (st_q == B_REND);
  assign rd_data   = rd_q;

endmodule

// File: rtl/flash_erase_ctrl.sv
module flash_erase_ctrl
  import flash_seq_pkg::*;
#(
  parameter int ADDR_W     = 17,
  parameter int WE_PW      = 8,
  parameter int GAP        = 750,
  parameter int OE_DLY     = 7,
  parameter int PROG_CYC   = 1250,
  parameter int ERASE_CYC  = 1250000,
  parameter int PROG_TRIES = 25,
  parameter int MAX_RETRY  = 1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              busy,
  output logic              done,
  output logic              pass,
  output logic              fail,
  output logic [ADDR_W-1:0] fl_addr,
  output logic [7:0]        fl_dq_out,
  output logic              fl_dq_oe,
  input  logic [7:0]        fl_dq_in,
  output logic              fl_ce_n,
  output logic              fl_oe_n,
  output logic              fl_we_n
);

  localparam logic [ADDR_W-1:0] LAST_ADDR = {ADDR_W{1'b1}};
  localparam int PT_W = $clog2(PROG_TRIES + 1);
  localparam int RT_W = $clog2(MAX_RETRY + 1);
  localparam int WMAX = (ERASE_CYC > PROG_CYC) ? ERASE_CYC : PROG_CYC;
  localparam int ST_W = $clog2(WMAX + 1);

  logic [1:0] rst_pipe_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= 2'b00;
    end else begin
      rst_pipe_q <= {rst_pipe_q[0], 1'b1};
    end
  end
  assign rst_int_n = rst_pipe_q[1];

  seq_st_e           state_q, state_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [PT_W-1:0]   tries_q, tries_d;
  logic [RT_W-1:0]   retries_q, retries_d;
  logic              done_q, done_d, pass_q, pass_d, fail_q, fail_d;
  logic              pend_q, pend_d;
  logic              is_op, req;
  bus_op_e           op;
  logic [7:0]        wdata;
  logic              eng_done;
  logic [7:0]        rd_data;
  logic              tld;
  logic [ST_W-1:0]   tval;
  logic              tzero;

  flash_wait_timer #(.W(ST_W)) u_pulse_tmr (
    .clk   (clk),
    .rst_n (rst_int_n),
    .load  (tld),
    .value (tval),
    .zero  (tzero)
  );

  flash_bus_engine #(
    .ADDR_W (ADDR_W),
    .WE_PW  (WE_PW),
    .GAP    (GAP),
    .OE_DLY (OE_DLY)
  ) u_bus (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .req       (req),
    .op        (op),
    .addr_in   (addr_q),
    .data_in   (wdata),
    .done      (eng_done),
    .rd_data   (rd_data),
    .fl_addr   (fl_addr),
    .fl_dq_out (fl_dq_out),
    .fl_dq_oe  (fl_dq_oe),
    .fl_dq_in  (fl_dq_in),
    .fl_ce_n   (fl_ce_n),
    .fl_oe_n   (fl_oe_n),
    .fl_we_n   (fl_we_n)
  );

  always_comb begin
    state_d   = state_q;
    addr_d    = addr_q;
    tries_d   = tries_q;
    retries_d = retries_q;
    done_d    = done_q;
    pass_d    = pass_q;
    fail_d    = fail_q;
    is_op     = 1'b0;
    op        = OP_WRITE;
    wdata     = BYTE_ZERO;
    tld       = 1'b0;
    tval      = '0;
    unique case (state_q)
      S_IDLE: begin
        // R2: start is looked at only here
        if (start) begin
          state_d   = S_PP_SET;
          addr_d    = '0;
          tries_d   = '0;
          retries_d = '0;
          done_d    = 1'b0;
          pass_d    = 1'b0;
          fail_d    = 1'b0;
        end
      end
      S_PP_SET: begin
        is_op = 1'b1;
        wdata = CMD_PROG_SETUP;
        if (eng_done) state_d = S_PP_DAT;
      end
      S_PP_DAT: begin
        is_op = 1'b1;
        wdata = BYTE_ZERO;
        if (eng_done) begin
          state_d = S_PP_WAIT;
          tld     = 1'b1;
          tval    = ST_W'(PROG_CYC - 1);
        end
      end
      S_PP_WAIT: if (tzero) state_d = S_PP_VSET;
      S_PP_VSET: begin
        is_op = 1'b1;
        wdata = CMD_PROG_VERIFY;
        if (eng_done) state_d = S_PP_VRD;
      end
      S_PP_VRD: begin
        is_op = 1'b1;
        op    = OP_READ;
        if (eng_done) begin
          if (rd_data == BYTE_ZERO) begin
            tries_d = '0;
            if (addr_q == LAST_ADDR) begin
              addr_d  = '0;
              state_d = S_ER_SET1;
            end else begin
              addr_d  = addr_q + ADDR_W'(1);
              state_d = S_PP_SET;
            end
          end else if (tries_q == PT_W'(PROG_TRIES - 1)) begin
            // R4: attempt limit reached on this byte
            state_d = S_IDLE;
            done_d  = 1'b1;
            fail_d  = 1'b1;
          end else begin
            tries_d = tries_q + PT_W'(1);
            state_d = S_PP_SET;
          end
        end
      end
      S_ER_SET1: begin
        is_op = 1'b1;
        wdata = CMD_ERASE;
        if (eng_done) state_d = S_ER_SET2;
      end
      S_ER_SET2: begin
        is_op = 1'b1;
        wdata = CMD_ERASE;
        if (eng_done) begin
          state_d = S_ER_WAIT;
          tld     = 1'b1;
          tval    = ST_W'(ERASE_CYC - 1);
        end
      end
      S_ER_WAIT: if (tzero) state_d = S_EV_SET;
      S_EV_SET: begin
        is_op = 1'b1;
        wdata = CMD_ERASE_VERIFY;
        if (eng_done) state_d = S_EV_RD;
      end
      S_EV_RD: begin
        is_op = 1'b1;
        op    = OP_READ;
        if (eng_done) begin
          if (rd_data == BYTE_ERASED) begin
            if (addr_q == LAST_ADDR) begin
              state_d = S_IDLE;
              done_d  = 1'b1;
              pass_d  = 1'b1;
            end else begin
              addr_d  = addr_q + ADDR_W'(1);
              state_d = S_EV_SET;
            end
          end else if (retries_q == RT_W'(MAX_RETRY)) begin
            // R8: no retries left
            state_d = S_IDLE;
            done_d  = 1'b1;
            fail_d  = 1'b1;
          end else begin
            // R7: re-erase, address kept
            retries_d = retries_q + RT_W'(1);
            state_d   = S_ER_SET1;
          end
        end
      end
      default: state_d = S_IDLE;
    endcase
    req    = is_op && !pend_q;
    pend_d = eng_done ? 1'b0 : (req ? 1'b1 : pend_q);
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      state_q   <= S_IDLE;
      addr_q    <= '0;
      tries_q   <= '0;
      retries_q <= '0;
      done_q    <= 1'b0;
      pass_q    <= 1'b0;
      fail_q    <= 1'b0;
      pend_q    <= 1'b0;
    end else begin
      state_q   <= state_d;
      addr_q    <= addr_d;
      tries_q   <= tries_d;
      retries_q <= retries_d;
      done_q    <= done_d;
      pass_q    <= pass_d;
      fail_q    <= fail_d;
      pend_q    <= pend_d;
    end
  end

  assign busy = (state_q != S_IDLE);
  assign done = done_q;
  assign pass = pass_q;
  assign fail = fail_q;

endmodule

// File: rtl/flash_erase_ctrl_chk.sv
module flash_erase_ctrl_chk #(
  parameter int GAP = 750
) (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic busy,
  input logic done,
  input logic pass,
  input logic fail,
  input logic fl_dq_oe,
  input logic fl_ce_n,
  input logic fl_oe_n,
  input logic fl_we_n
);

  localparam int GW = $clog2(GAP + 1);

  logic [GW-1:0] since_rise_q;
  logic          we_prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_rise_q <= GW'(GAP);
      we_prev_q    <= 1'b1;
    end else begin
      we_prev_q <= fl_we_n;
      if (fl_we_n && !we_prev_q) begin
        since_rise_q <= GW'(1);
      end else if (since_rise_q < GW'(GAP)) begin
        since_rise_q <= since_rise_q + GW'(1);
      end
    end
  end

  p_strobe_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(!fl_we_n && !fl_oe_n));

  p_we_selects_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !fl_we_n |-> (!fl_ce_n && fl_dq_oe));

  p_oe_selects_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !fl_oe_n |-> !fl_ce_n);

  p_no_drive_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !fl_oe_n |-> !fl_dq_oe);

  p_read_gap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fl_oe_n) |-> (since_rise_q >= GW'(GAP)));

  p_start_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);

  p_done_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> (done && $stable(pass) && $stable(fail)));

  p_verdict_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (pass || fail) |-> (done && (pass != fail)));

endmodule

bind flash_erase_ctrl flash_erase_ctrl_chk #(.GAP(GAP)) u_chk (
  .clk      (clk),
  .rst_n    (rst_int_n),
  .start    (start),
  .busy     (busy),
  .done     (done),
  .pass     (pass),
  .fail     (fail),
  .fl_dq_oe (fl_dq_oe),
  .fl_ce_n  (fl_ce_n),
  .fl_oe_n  (fl_oe_n),
  .fl_we_n  (fl_we_n)
);

// File: tb/flash_erase_ctrl_test.sv
module flash_erase_ctrl_test;

  localparam int AW = 3, DEPTH = 8, WE_PW = 2, GAP = 6, OE_DLY = 3;
  localparam int PROG_CYC = 8, ERASE_CYC = 40, PT = 4, MR = 3;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic busy, done, pass, fail, fl_dq_oe, fl_ce_n, fl_oe_n, fl_we_n;
  logic [AW-1:0] fl_addr;
  logic [7:0] fl_dq_out, fl_dq_in;

  always #4 clk = ~clk;

  flash_erase_ctrl #(
    .ADDR_W(AW), .WE_PW(WE_PW), .GAP(GAP), .OE_DLY(OE_DLY),
    .PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC), .PROG_TRIES(PT), .MAX_RETRY(MR)
  ) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .pass(pass), .fail(fail), .fl_addr(fl_addr), .fl_dq_out(fl_dq_out),
    .fl_dq_oe(fl_dq_oe), .fl_dq_in(fl_dq_in), .fl_ce_n(fl_ce_n),
    .fl_oe_n(fl_oe_n), .fl_we_n(fl_we_n)
  );

  int checks = 0, errors = 0, cyc = 0;
  int prog_need [DEPTH];
  int erase_need[DEPTH];
  int prog_cnt  [DEPTH];
  int pulses, rd_mode, oe_cnt, erase_start, last_rise;
  bit pset, programming, armed, erasing, exp_pass;
  logic prev_we = 1'b1, prev_oe = 1'b1;
  int exp_q[$];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // Behavioural flash: real data only after OE_DLY cycles of output-enable low
  always_comb begin
    fl_dq_in = 8'h5A;
    if (oe_cnt >= OE_DLY) begin
      if (rd_mode == 1)
        fl_dq_in = (prog_cnt[fl_addr] >= prog_need[fl_addr]) ? 8'h00 : 8'h01;
      else if (rd_mode == 2)
        fl_dq_in = (pulses >= erase_need[fl_addr]) ? 8'hFF : 8'h7F;
    end
  end

  task automatic bus_event(input int code);
    int exp;
    if (exp_q.size() == 0) begin
      check(1'b0, "R3 R6 R7 extra bus cycle", code, 0);
    end else begin
      exp = exp_q.pop_front();
      check(code == exp, "R3 R4 R5 R6 R7 bus sequence", code, exp);
    end
  endtask

  task automatic on_write(input int a, input int d);
    last_rise = cyc;
    bus_event((1 << 16) | (a << 8) | d);
    if (pset) begin
      pset = 0; programming = 1;
    end else if (d == 'h40) begin
      pset = 1; armed = 0;
    end else if (d == 'hC0) begin
      if (programming) prog_cnt[a]++;
      programming = 0; rd_mode = 1; armed = 0;
    end else if (d == 'h20) begin
      if (armed) begin erasing = 1; erase_start = cyc; armed = 0; end
      else armed = 1;
    end else if (d == 'hA0) begin
      if (erasing) begin
        check(cyc - erase_start >= ERASE_CYC, "R5 erase pulse length",
              cyc - erase_start, ERASE_CYC);
        pulses++;
      end
      erasing = 0; rd_mode = 2; armed = 0;
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    oe_cnt = (fl_oe_n == 1'b0) ? oe_cnt + 1 : 0;
    if (rst_n) begin
      check(!((!fl_we_n || !fl_oe_n) && fl_ce_n), "R10 strobe without chip enable",
            fl_ce_n, 0);
      check(!(!fl_we_n && !fl_oe_n), "R10 strobes overlap", 1, 0);
      check(!(pass && fail), "R11 pass and fail", {pass, fail}, 0);
      if (fl_we_n && !prev_we) on_write(int'(fl_addr), int'(fl_dq_out));
      if (!fl_oe_n && prev_oe)
        check(cyc - last_rise >= GAP, "R9 write-to-read gap", cyc - last_rise, GAP);
      if (fl_oe_n && !prev_oe) bus_event((2 << 16) | (int'(fl_addr) << 8));
    end
    prev_we = fl_we_n;
    prev_oe = fl_oe_n;
  end

  task automatic push(input int k, input int a, input int d);
    exp_q.push_back((k << 16) | (a << 8) | d);
  endtask

  task automatic build_expected();
    int retries, pl, a;
    exp_q.delete();
    exp_pass = 0;
    for (int b = 0; b < DEPTH; b++) begin
      for (int t = 1; ; t++) begin
        push(1, b, 'h40); push(1, b, 'h00); push(1, b, 'hC0); push(2, b, 0);
        if (t >= prog_need[b]) break;
        if (t == PT) return;
      end
    end
    pl = 1; retries = 0; a = 0;
    push(1, 0, 'h20); push(1, 0, 'h20);
    forever begin
      push(1, a, 'hA0); push(2, a, 0);
      if (pl >= erase_need[a]) begin
        if (a == DEPTH - 1) begin exp_pass = 1; return; end
        a++;
      end else begin
        if (retries == MR) return;
        retries++; pl++;
        push(1, a, 'h20); push(1, a, 'h20);
      end
    end
  endtask

  task automatic set_defaults();
    for (int i = 0; i < DEPTH; i++) begin
      prog_need[i] = 1; erase_need[i] = 1;
    end
  endtask

  task automatic run_case(input string req, input int poke);
    int waited;
    for (int i = 0; i < DEPTH; i++) prog_cnt[i] = 0;
    pulses = 0; rd_mode = 0; pset = 0; programming = 0; armed = 0; erasing = 0;
    build_expected();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    check(busy == 1'b1, "R2 busy after start", busy, 1);
    check(done == 1'b0, "R2 done cleared by start", done, 0);
    if (poke > 0) begin
      repeat (poke) @(negedge clk);
      start = 1'b1; @(negedge clk); start = 1'b0;
      @(negedge clk);
      check(busy == 1'b1 && done == 1'b0, "R2 start while busy ignored", {busy, done}, 2);
    end
    waited = 0;
    while (!done && waited < 20000) begin
      @(negedge clk); waited++;
    end
    check(done == 1'b1, {req, " run completes"}, done, 1);
    check(pass == exp_pass, {req, " pass verdict"}, pass, exp_pass);
    check(fail == !exp_pass, {req, " fail verdict"}, fail, !exp_pass);
    check(exp_q.size() == 0, {req, " all expected bus cycles seen"}, exp_q.size(), 0);
    repeat (6) @(negedge clk);
    check(done && !busy && pass == exp_pass, "R11 verdict held", {done, busy, pass},
          {1'b1, 1'b0, exp_pass});
  endtask

  initial begin
    set_defaults();
    repeat (3) @(negedge clk);
    check(fl_ce_n && fl_we_n && fl_oe_n && !fl_dq_oe, "R1 strobes in reset",
          {fl_ce_n, fl_we_n, fl_oe_n, fl_dq_oe}, 4'b1110);
    check(!busy && !done && !pass && !fail, "R1 status in reset",
          {busy, done, pass, fail}, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check(fl_ce_n && fl_we_n && fl_oe_n && !fl_dq_oe && !busy && !done,
          "R1 idle after reset", {fl_ce_n, fl_we_n, fl_oe_n, busy}, 4'b1110);

    // Every byte good first time
    set_defaults();
    run_case("R3 R6", 0);

    // Program retries up to the limit, erase retries up to exactly MAX_RETRY
    set_defaults();
    prog_need[2] = 3; prog_need[7] = PT;
    erase_need[3] = 2; erase_need[6] = MR + 1;
    run_case("R4 R7 R8 boundary", 0);

    // One byte never programs
    set_defaults();
    prog_need[5] = PT + 1;
    run_case("R4 program limit", 0);

    // One byte needs more than MAX_RETRY extra erase pulses
    set_defaults();
    erase_need[4] = MR + 2;
    run_case("R8 erase limit", 0);

    // Start pulse in the middle of a run
    set_defaults();
    erase_need[1] = 2;
    run_case("R2 R7", 50);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    forever begin
      @(negedge clk);
      if (cyc > 150000) begin
        check(1'b0, "watchdog", cyc, 150000);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

endmodule